// File: doc/BRIEF.md
# Low-Frequency Countdown Timer with Interrupt

This block is a down-counting timer driven by a slow time base (nominally 32,768 Hz), which arrives as a single-cycle tick-enable strobe in the system clock domain. Software reaches it through a small word-addressed register bus with separate read and write strobes. It programs a reload value and a control word, and it can read the live count at any time. It can also read the interrupt state. Reading a dedicated acknowledge register clears a pending interrupt.

The counter loads the reload value when it is switched on. It then moves down by one on every tick. When a tick arrives while the count is zero, the timer expires. What happens next depends on the mode. In periodic mode the counter takes the reload value again. In free-running mode it rolls over to all ones. Each expiry sets a sticky event flag. A mask bit in the control word gates the flag onto the interrupt pin and the status bit. Setting the mask bit to 1 blocks the interrupt. The flag itself keeps its state while masked, so clearing the mask exposes an event that arrived during the masked period.

Top module: `lftimer`

## Requirements
- R1: After reset, irq is 0 and the reload, control, count and status registers all read 0, so the timer is stopped.
- R2: The register map uses word addresses: 0 is reload (read/write), 1 is control (read/write, bits [2:0]), 2 is count (read-only), 3 is status (read-only) and 4 is acknowledge. Unmapped addresses read 0. rdata is combinational and is valid while rd_en is high. Control bit 0 is run, bit 1 is periodic and bit 2 is mask.
- R3: A control write that changes run from 0 to 1 loads the counter with the reload value.
- R4: While run is 1, each tick_en cycle decrements the count by one. With run at 0, or with no tick, the count holds.
- R5: In free-running mode (bit 1 = 0), a tick at count 0 sets the event flag and the count becomes 0xFFFFFFFF.
- R6: In periodic mode (bit 1 = 1), a tick at count 0 sets the event flag and reloads the count from the reload register.
- R7: irq and status bit 0 equal the event flag while the mask bit is 0, and are 0 while it is 1. The flag is kept while masked, and clearing the mask exposes it.
- R8: A read of address 4 clears the event flag and returns 0. Writes to addresses 2, 3 and 4 have no effect.
- R9: If an expiry and an acknowledge read happen in the same cycle, the event flag stays set.
- R10: A control write with run = 1 while the timer is already running does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle strobe from the slow time base |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 4 clears the event |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when rd_en is low |
| irq | output | 1 | Interrupt, event flag gated by the mask bit |

## Verification
The hardest case to reach is an expiry that lands in the same cycle as an acknowledge read. The bench decrements a periodic count to zero. It then raises tick_en and the acknowledge read in the same cycle and checks that the interrupt survives. A second hard case is an event that arrives while the mask is set. To reach it, the bench masks the interrupt and lets the counter expire. It checks that irq and status stay low, then clears the mask and expects the interrupt to appear without any further tick.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD = 3'd0,
    REG_CTRL   = 3'd1,
    REG_COUNT  = 3'd2,
    REG_STATUS = 3'd3,
    REG_ACK    = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lft_regs.sv
module lft_regs
  import lft_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              status,
  output logic [CNT_W-1:0]  reload,
  output ctrl_t             ctrl,
  output logic              start,
  output logic              ack_rd,
  output logic [CNT_W-1:0]  rdata
);
  reg_sel_e         sel;
  logic [CNT_W-1:0] reload_d, reload_q;
  ctrl_t            ctrl_d, ctrl_q;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    if (wr_en) begin
      case (sel)
        REG_RELOAD: reload_d = wdata;
        REG_CTRL:   ctrl_d   = ctrl_t'(wdata[CTRL_W-1:0]);
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
    end
  end

  assign start  = wr_en && (sel == REG_CTRL) && wdata[0] && !ctrl_q.run;
  assign ack_rd = rd_en && (sel == REG_ACK);
  assign reload = reload_q;
  assign ctrl   = ctrl_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        REG_RELOAD: rdata = reload_q;
        REG_CTRL:   rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        REG_COUNT:  rdata = count;
        REG_STATUS: rdata = {{(CNT_W-1){1'b0}}, status};
        default:    rdata = '0;
      endcase
    end
  end

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == REG_CTRL |=> ctrl_q == $past(wdata[CTRL_W-1:0]));
  a_r8_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel != REG_RELOAD && sel != REG_CTRL |=> $stable(reload_q) && $stable(ctrl_q));
endmodule

// File: rtl/lft_counter.sv
module lft_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             periodic,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             step;

  assign step   = run && tick_en && !start;
  assign expire = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = reload;
    end else if (step) begin
      if (cnt_q == '0 && periodic) cnt_d = reload;
      else                         cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(reload));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !(run && tick_en) |=> $stable(cnt_q));
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    !start && run && tick_en && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !periodic |=> &cnt_q);
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && periodic |=> cnt_q == $past(reload));
endmodule

// File: rtl/lft_irq.sv
module lft_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_rd,
  input  logic mask,
  output logic irq,
  output logic pend
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (expire)      flag_d = 1'b1;
    else if (ack_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign pend = flag_q && !mask;
  assign irq  = pend;

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !expire |=> !flag_q);
  a_r7_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !ack_rd |=> flag_q);
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ack_rd |=> flag_q);
endmodule

// File: rtl/lftimer.sv
module lftimer
  import lft_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [CNT_W-1:0] count, reload;
  ctrl_t            ctrl;
  logic             start, ack_rd, expire, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lft_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .status(pend), .reload(reload), .ctrl(ctrl),
    .start(start), .ack_rd(ack_rd), .rdata(rdata)
  );

  lft_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en), .run(ctrl.run),
    .periodic(ctrl.periodic), .start(start), .reload(reload), .count(count),
    .expire(expire)
  );

  lft_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .expire(expire), .ack_rd(ack_rd),
    .mask(ctrl.mask), .irq(irq), .pend(pend)
  );

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl.mask |-> !irq);
  a_r1_stopped_after_reset: assert property (@(posedge clk)
    $rose(rst_int_n) |-> !ctrl.run && !irq);
endmodule

// File: tb/tb_lftimer.sv
module tb_lftimer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;

  localparam logic [2:0] A_RELOAD = 3'd0, A_CTRL = 3'd1, A_COUNT = 3'd2,
                         A_STATUS = 3'd3, A_ACK = 3'd4;

  always #10 clk = ~clk;

  lftimer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
               .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, irq}, 32'd0);
    expect_reg("R1 reload", A_RELOAD, 32'd0);
    expect_reg("R1 ctrl", A_CTRL, 32'd0);
    expect_reg("R1 count", A_COUNT, 32'd0);
    expect_reg("R1 status", A_STATUS, 32'd0);
  endtask

  task automatic t_map;
    bus_write(A_RELOAD, 32'h1234_5678);
    expect_reg("R2 reload readback", A_RELOAD, 32'h1234_5678);
    bus_write(A_CTRL, 32'hFFFF_FFF6);
    expect_reg("R2 ctrl readback", A_CTRL, 32'd6);
    bus_write(A_CTRL, 32'd0);
    expect_reg("R2 unmapped", 3'd7, 32'd0);
    @(negedge clk); addr = A_RELOAD; #1;
    check("R2 rdata idle", rdata, 32'd0);
    ticks(3);
    expect_reg("R4 disabled hold", A_COUNT, 32'd0);
  endtask

  task automatic t_freerun;
    bus_write(A_RELOAD, 32'd5);
    bus_write(A_CTRL, 32'd1);
    expect_reg("R3 start load", A_COUNT, 32'd5);
    ticks(2);
    expect_reg("R4 decrement", A_COUNT, 32'd3);
    repeat (4) @(negedge clk);
    expect_reg("R4 hold no tick", A_COUNT, 32'd3);
    ticks(3);
    expect_reg("R5 at zero", A_COUNT, 32'd0);
    check("R5 no irq yet", {31'd0, irq}, 32'd0);
    ticks(1);
    expect_reg("R5 wrap", A_COUNT, 32'hFFFF_FFFF);
    check("R5 irq", {31'd0, irq}, 32'd1);
    expect_reg("R7 status", A_STATUS, 32'd1);
  endtask

  task automatic t_ack;
    expect_reg("R8 ack rdata", A_ACK, 32'd0);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);
    expect_reg("R8 status cleared", A_STATUS, 32'd0);
    bus_write(A_COUNT, 32'd7);
    bus_write(A_STATUS, 32'd1);
    bus_write(A_ACK, 32'd1);
    expect_reg("R8 count write ignored", A_COUNT, 32'hFFFF_FFFF);
    expect_reg("R8 status write ignored", A_STATUS, 32'd0);
    expect_reg("R8 ctrl untouched", A_CTRL, 32'd1);
    bus_write(A_RELOAD, 32'd9);
    bus_write(A_CTRL, 32'd5);
    expect_reg("R10 no reload while running", A_COUNT, 32'hFFFF_FFFF);
    bus_write(A_CTRL, 32'd0);
    ticks(2);
    expect_reg("R4 stopped hold", A_COUNT, 32'hFFFF_FFFF);
  endtask

  task automatic t_periodic;
    bus_write(A_RELOAD, 32'd2);
    bus_write(A_CTRL, 32'd3);
    expect_reg("R3 periodic start", A_COUNT, 32'd2);
    ticks(3);
    expect_reg("R6 reload", A_COUNT, 32'd2);
    check("R6 irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_mask;
    bus_write(A_CTRL, 32'd7);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    expect_reg("R7 masked status", A_STATUS, 32'd0);
    bus_write(A_CTRL, 32'd3);
    check("R7 unmask exposes", {31'd0, irq}, 32'd1);
    expect_reg("R8 ack", A_ACK, 32'd0);
    bus_write(A_CTRL, 32'd7);
    ticks(3);
    check("R7 event while masked", {31'd0, irq}, 32'd0);
    expect_reg("R7 status while masked", A_STATUS, 32'd0);
    bus_write(A_CTRL, 32'd3);
    check("R7 late expose", {31'd0, irq}, 32'd1);
    expect_reg("R7 status exposed", A_STATUS, 32'd1);
    expect_reg("R8 ack again", A_ACK, 32'd0);
    check("R8 cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_collide;
    ticks(2);
    expect_reg("R9 at zero", A_COUNT, 32'd0);
    @(negedge clk); tick_en = 1'b1; rd_en = 1'b1; addr = A_ACK;
    @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
    check("R9 event wins", {31'd0, irq}, 32'd1);
    expect_reg("R9 reloaded", A_COUNT, 32'd2);
    expect_reg("R8 final ack", A_ACK, 32'd0);
    check("R9 cleared after", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_freerun();
    t_ack();
    t_periodic();
    t_mask();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule